// File: doc/BRIEF.md
# Ping-Pong Frame Capture Buffer

This block captures fixed-length frames from a producer that can supply one word per clock. It holds two equal register banks. One bank is filled while the other bank is served to a consumer. Each frame is `DEPTH` words of `WIDTH` bits. Within a frame the words are stored in descending slot order: the first accepted word goes to the highest slot and the last accepted word goes to slot 0. When a frame is complete the two banks trade roles. The freshly filled bank becomes readable and the other bank takes the next frame.

The consumer reads any whole entry of the readable bank through a registered multiplexer. It can use any index, in any order, with repeats allowed. A compile-time option selects how the fill is built:
- **Pointer fill:** a decrementing write position that steers each word to its slot.
- **Shift fill:** a chain that always writes slot 0 and moves older entries down one slot. Per-stage enable bits stop the toggling once the data has settled.

The input is a valid/ready stream. The block never applies back-pressure: `in_ready` is high in every cycle after the first clock that follows reset, so a producer with no stall path can drive it. Words are taken only on cycles where `in_valid` and `in_ready` are both high. Idle cycles pause the fill and lose nothing.

Top module: `pp_capture_buf`

## Requirements
- R1: A synchronous reset clears the fill position, the shift-enable bits, the readable-bank indicator (`rd_bank`=0), `frame_done`, `frame_ready` and `rd_data`. `in_ready` is low during reset. A partly filled frame is discarded.
- R2: Within a frame, the k-th accepted word (k counted from 1) is stored in slot `DEPTH-k` of the bank being filled. The first word goes to slot `DEPTH-1` and the last word to slot 0.
- R3: The fill advances only on cycles where `in_valid` and `in_ready` are both high. Idle cycles do not count toward the `DEPTH` words of a frame.
- R4: On the clock edge that accepts the `DEPTH`-th word of a frame, `rd_bank` toggles. For the following cycle only, `frame_done` is high.
- R5: The readable bank is not altered while the other bank is filling. Reads made during a fill return the previously completed frame.
- R6: `rd_data` is registered. The index presented in cycle t gives its entry in cycle t+1, taken from the bank that was readable in cycle t. This also holds on the swap edge.
- R7: `frame_ready` stays low until the first complete frame after reset and then stays high. While it is low, `rd_data` is zero.
- R8: Reads may use any index in any order and may repeat. Each read returns the whole entry of the selected slot.
- R9: The pointer fill and the shift fill give identical `rd_data`, `rd_bank`, `frame_done` and `frame_ready` for the same input sequence.
- R10: `in_ready` is high in every cycle after the first clock following reset. The block never stalls the producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer word valid |
| in_ready | output | 1 | Block accepts a word (high after reset) |
| in_data | input | WIDTH | Producer word |
| rd_idx | input | $clog2(DEPTH) | Slot to read from the readable bank |
| rd_data | output | WIDTH | Registered entry for the previous cycle's index |
| rd_bank | output | 1 | Bank currently readable (the other one fills) |
| frame_done | output | 1 | One-cycle pulse after a frame completes |
| frame_ready | output | 1 | A complete frame has been captured since reset |

## Verification
The bench builds two copies of the block, each with `WIDTH`=16 and `DEPTH`=8. One copy uses the pointer fill and the other uses the shift fill. They see the same stimulus and are compared with each other and with a bench-side model. The short depth lets many consecutive swaps, gapped fills, reads during fills and a reset in the middle of a frame fit into a few hundred cycles. The narrow width is still enough to tag every word with both its frame number and its position, so a misplaced slot or a wrong bank shows up as a wrong value.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic {
    FILL_PTR   = 1'b0,
    FILL_SHIFT = 1'b1
  } fill_e;
endpackage

// File: rtl/pp_seq.sv
module pp_seq #(
  parameter int DEPTH = 128,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  output logic [IW-1:0] cnt,
  output logic          last,
  output logic          rd_bank,
  output logic          frame_done,
  output logic          frame_ready
);
  localparam logic [IW-1:0] LAST_CNT = IW'(DEPTH - 1);

  assign last = acc && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      rd_bank     <= 1'b0;
      frame_done  <= 1'b0;
      frame_ready <= 1'b0;
    end else begin
      frame_done <= last;
      if (acc) begin
        if (last) begin
          cnt         <= '0;
          rd_bank     <= ~rd_bank;
          frame_ready <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3: idle cycles leave the fill position unchanged
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(cnt));
  // R4: a done pulse always follows a bank swap
  a_r4_done_toggle: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_done) |-> (rd_bank != $past(rd_bank)));
  // R4: the pulse lasts a single cycle
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  // R7: readiness is sticky
  a_r7_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    frame_ready |=> frame_ready);
endmodule

// File: rtl/pp_bank_ptr.sv
module pp_bank_ptr #(
  parameter int WIDTH = 256,
  parameter int DEPTH = 128,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    cnt,
  input  logic [WIDTH-1:0] din,
  input  logic [IW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_word
);
  localparam logic [IW-1:0] TOP = IW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [IW-1:0]    slot;

  // descending placement: first word of a frame lands in the top slot
  assign slot    = TOP - cnt;
  assign rd_word = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (we) mem[slot] <= din;
  end
endmodule

// File: rtl/pp_bank_shift.sv
module pp_bank_shift #(
  parameter int WIDTH = 256,
  parameter int DEPTH = 128,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             last,
  input  logic [WIDTH-1:0] din,
  input  logic [IW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_word
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [DEPTH-2:0] sen;

  assign rd_word = mem[rd_idx];

  // enable bits: slot 0 set by the first word, each later bit follows its
  // predecessor one accepted word later; all cleared at frame end
  always_ff @(posedge clk) begin
    if (rst) begin
      sen <= '0;
    end else if (we) begin
      if (last) begin
        sen <= '0;
      end else begin
        sen[0] <= 1'b1;
        for (int i = 1; i < DEPTH - 1; i++) sen[i] <= sen[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem[0] <= din;
      for (int i = 1; i < DEPTH; i++) begin
        if (sen[i-1]) mem[i] <= mem[i-1];
      end
    end
  end

  // R2: chain goes quiet once a frame is complete
  a_r2_sen_cleared: assert property (@(posedge clk) disable iff (rst)
    last |=> (sen == '0));
  // R2: after a non-final word slot 0 is enabled to move on
  a_r2_sen_head: assert property (@(posedge clk) disable iff (rst)
    (we && !last) |=> sen[0]);
endmodule

// File: rtl/pp_capture_buf.sv
module pp_capture_buf #(
  parameter int            WIDTH = 256,
  parameter int            DEPTH = 128,
  parameter pp_pkg::fill_e FILL  = pp_pkg::FILL_PTR,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic [IW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_bank,
  output logic             frame_done,
  output logic             frame_ready
);
  localparam int NBANK = 2;

  logic             rdy_q;
  logic             acc;
  logic [IW-1:0]    cnt;
  logic             last;
  logic [WIDTH-1:0] bank_rd [NBANK];

  assign in_ready = rdy_q;
  assign acc      = in_valid && rdy_q;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  pp_seq #(.DEPTH(DEPTH)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .acc        (acc),
    .cnt        (cnt),
    .last       (last),
    .rd_bank    (rd_bank),
    .frame_done (frame_done),
    .frame_ready(frame_ready)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic we_b;
    // the bank not being read is the one being filled
    assign we_b = acc && (rd_bank != b[0]);
    if (FILL == pp_pkg::FILL_SHIFT) begin : g_shift
      pp_bank_shift #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (we_b),
        .last   (last),
        .din    (in_data),
        .rd_idx (rd_idx),
        .rd_word(bank_rd[b])
      );
    end else begin : g_ptr
      pp_bank_ptr #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
        .clk    (clk),
        .we     (we_b),
        .cnt    (cnt),
        .din    (in_data),
        .rd_idx (rd_idx),
        .rd_word(bank_rd[b])
      );
    end
  end

  // registered read port, sourced from the bank readable in this cycle
  always_ff @(posedge clk) begin
    if (rst)              rd_data <= '0;
    else if (frame_ready) rd_data <= bank_rd[rd_bank];
    else                  rd_data <= '0;
  end

  // R7: nothing leaks out before the first full frame
  a_r7_zero_before_ready: assert property (@(posedge clk) disable iff (rst)
    !frame_ready |=> (rd_data == '0));
  // R10: the producer is never stalled once out of reset
  a_r10_ready_high: assert property (@(posedge clk) disable iff (rst)
    !rst |=> in_ready);
endmodule

// File: tb/pp_capture_buf_bench.sv
module pp_capture_buf_bench;
  localparam int W  = 16;
  localparam int D  = 8;
  localparam int IW = $clog2(D);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [IW-1:0] rd_idx = '0;

  logic rdy_a, rdy_b, bank_a, bank_b, done_a, done_b, fr_a, fr_b;
  logic [W-1:0] rd_a, rd_b;

  always #5 clk = ~clk;

  pp_capture_buf #(.WIDTH(W), .DEPTH(D), .FILL(pp_pkg::FILL_PTR)) u_pp_capture_buf (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_a), .in_data(in_data),
    .rd_idx(rd_idx), .rd_data(rd_a), .rd_bank(bank_a), .frame_done(done_a),
    .frame_ready(fr_a));

  pp_capture_buf #(.WIDTH(W), .DEPTH(D), .FILL(pp_pkg::FILL_SHIFT)) u_pp_capture_buf_shift (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_b), .in_data(in_data),
    .rd_idx(rd_idx), .rd_data(rd_b), .rd_bank(bank_b), .frame_done(done_b),
    .frame_ready(fr_b));

  int checks = 0;
  int errors = 0;

  logic [W-1:0] mbank [2][D];
  int mcnt;
  bit mrd;
  bit mready;
  int frame_no;
  logic [7:0] lfsr = 8'h5a;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] word(input int f, input int k);
    return W'((f << 8) | k);
  endfunction

  // one cycle: drive at negedge, model, compare after the edge
  task automatic step(input bit v, input logic [W-1:0] d, input int idx);
    logic [W-1:0] exp_rd;
    bit exp_done;
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    rd_idx   = IW'(idx);
    exp_rd   = mready ? mbank[int'(mrd)][idx] : '0;
    exp_done = 1'b0;
    if (v) begin
      mbank[int'(!mrd)][D-1-mcnt] = d;
      mcnt++;
      if (mcnt == D) begin
        mcnt = 0; mrd = !mrd; mready = 1'b1; exp_done = 1'b1;
      end
    end
    @(posedge clk); #1;
    chk(rd_a == exp_rd, "R6 rd_data ptr", rd_a, exp_rd);
    chk(rd_b == exp_rd, "R6 rd_data shift", rd_b, exp_rd);
    chk(rd_a == rd_b, "R9 fill variants agree", rd_b, rd_a);
    chk(done_a == exp_done && done_b == exp_done, "R4 frame_done", {done_a, done_b}, {exp_done, exp_done});
    chk(bank_a == mrd && bank_b == mrd, "R4 rd_bank", {bank_a, bank_b}, {mrd, mrd});
    chk(fr_a == mready && fr_b == mready, "R7 frame_ready", {fr_a, fr_b}, {mready, mready});
    chk(rdy_a && rdy_b, "R10 in_ready", {rdy_a, rdy_b}, 2'b11);
  endtask

  function automatic int next_idx();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return int'(lfsr) % D;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(bank_a == 0 && bank_b == 0, "R1 rd_bank reset", {bank_a, bank_b}, 0);
    chk(!done_a && !done_b, "R1 frame_done reset", {done_a, done_b}, 0);
    chk(!fr_a && !fr_b, "R1 frame_ready reset", {fr_a, fr_b}, 0);
    chk(rd_a == 0 && rd_b == 0, "R1 rd_data reset", {rd_a, rd_b}, 0);
    chk(!rdy_a && !rdy_b, "R1 in_ready low in reset", {rdy_a, rdy_b}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    mcnt = 0; mrd = 1'b0; mready = 1'b0;
  endtask

  // R7 before the first frame, R2 slot order via model
  task automatic t_first_frame();
    frame_no++;
    for (int k = 1; k <= D; k++) step(1'b1, word(frame_no, k), next_idx());
  endtask

  // R2: explicit slot check, the k-th word sits in slot D-k
  task automatic t_slot_order();
    for (int k = 1; k <= D; k++) begin
      step(1'b0, '0, D - k);
      chk(rd_a == word(frame_no, k), "R2 slot order ptr", rd_a, word(frame_no, k));
      chk(rd_b == word(frame_no, k), "R2 slot order shift", rd_b, word(frame_no, k));
    end
  endtask

  // R3 gaps do not count, R5 reads during fill return old frame
  task automatic t_gappy_fill();
    int prev = frame_no;
    frame_no++;
    for (int k = 1; k <= D; k++) begin
      step(1'b0, W'(16'hdead), k % D);
      step(1'b1, word(frame_no, k), D - 1);
      if (k < D) chk(rd_a == word(prev, 1), "R5 old frame during fill", rd_a, word(prev, 1));
    end
    step(1'b0, '0, D - 1);
    chk(rd_a == word(frame_no, 1), "R3 gapped frame top slot", rd_a, word(frame_no, 1));
  endtask

  // R8 random order and repeats; back-to-back frames
  task automatic t_random_reads();
    for (int f = 0; f < 3; f++) begin
      frame_no++;
      for (int k = 1; k <= D; k++) step(1'b1, word(frame_no, k), next_idx());
    end
    for (int r = 0; r < 4; r++) begin
      step(1'b0, '0, 3);
      chk(rd_b == word(frame_no, D - 3), "R8 repeated read", rd_b, word(frame_no, D - 3));
    end
    for (int r = 0; r < 3 * D; r++) step(1'b0, '0, next_idx());
  endtask

  // R1: reset mid-frame discards the partial frame
  task automatic t_mid_reset();
    frame_no++;
    for (int k = 1; k <= 3; k++) step(1'b1, word(frame_no, k), 0);
    t_reset();
    step(1'b0, '0, 2);
    chk(rd_a == 0 && !fr_a, "R1 not ready after mid reset", rd_a, 0);
    frame_no++;
    for (int k = 1; k <= D; k++) step(1'b1, word(frame_no, k), k - 1);
    t_slot_order();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    frame_no = 0;
    t_reset();
    t_first_frame();
    t_slot_order();
    t_gappy_fill();
    t_random_reads();
    t_mid_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule